// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives a host a single 32-bit control word through which it reaches a small bank of PHY delay settings that are not mapped into the host address space. The host writes the target PHY address and a data byte into the word, then raises a write strobe or a read strobe. The port turns that level into a request on a narrow PHY-side channel. The PHY answers with a one-cycle completion pulse, and the port reports completion back through a read-only acknowledge bit in the same word.

The host drops the strobe once it sees the acknowledge. The acknowledge then falls and the port is ready for the next access. For a read, the byte the PHY returns is captured into the word and stays there until another read completes. A behavioural PHY responder is also provided. It holds the delay entries and answers after a fixed latency. It is meant for testing and is not instantiated under the top.

The host is expected to give up on an access if the acknowledge does not appear within about ten microseconds. That limit is a software timeout, so the port has no timer of its own.

Top module: `phy_indirect_port`

## Requirements
- R1: After a synchronous active-high reset, the control word reads as 0x0000_0000, and `phy_req` and `phy_we` are low.
- R2: A host write to the word loads bits 5:0 as the PHY address, bits 15:8 as the write byte, bit 24 as the write strobe and bit 25 as the read strobe. Bits written into 23:16 (read byte) and 26 (acknowledge) are ignored. Bits 7:6 and 31:27 always read 0.
- R3: Only host offset 0x10 selects the word. A write to any other offset changes nothing, and a read of any other offset returns 0. Read data appears on `host_rdata` one cycle after `host_rd` and shows the word as it stood before that edge.
- R4: When the port is idle and a strobe is set in the word, `phy_req` rises one clock later. The address and write byte come from the word at that edge. `phy_we` is 1 for the write strobe (bit 24) and 0 for the read strobe (bit 25). If both strobes are set, the write wins. Address, data and direction stay fixed while `phy_req` is high.
- R5: `phy_req` stays high until the cycle in which `phy_done` is seen, and is low from the following cycle.
- R6: The acknowledge bit (26) rises in the cycle after `phy_done`. It stays high while either strobe bit is set, and falls one cycle after both strobes are clear.
- R7: On a read access, `phy_rdata` is captured into bits 23:16 in the same cycle the acknowledge rises. The captured byte is kept through later write accesses until the next read completes.
- R8: Setting a strobe while the acknowledge is high starts no access. No `phy_req` appears until the acknowledge has fallen.
- R9: The responder stores bytes only at PHY addresses 0x00 to 0x08 and 0x0B to 0x0D. A read of any other address returns 0, and a write to it is dropped. `phy_done` is a one-cycle pulse issued LAT+1 cycles after `phy_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_off | input | OFF_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| phy_req | output | 1 | Access request to the PHY, held until completion |
| phy_we | output | 1 | 1 = write access, 0 = read access |
| phy_addr | output | 6 | PHY register address |
| phy_wdata | output | 8 | Byte to write into the PHY |
| phy_rdata | input | 8 | Byte returned by the PHY, valid with phy_done |
| phy_done | input | 1 | One-cycle completion pulse from the PHY |

## Verification
The in-line properties check the request/completion protocol on every cycle. They cover the request being held until completion and dropped right after it, the acknowledge following completion, no request while the acknowledge is high, stable address and direction during a request, and completion pulses arising only from a request. Other behaviours are only visible through the host word, so the bench scenarios must show them: field packing, ignored writes to the read-only fields, offset decoding, read-byte capture and its retention across writes, write priority when both strobes are set, the responder's address map, and the exact cycles at which the acknowledge rises and falls.

// File: rtl/phyport_pkg.sv
package phyport_pkg;

  localparam int WORD_W    = 32;
  localparam int PA_W      = 6;
  localparam int PD_W      = 8;

  localparam int F_ADDR_LSB  = 0;
  localparam int F_WDAT_LSB  = 8;
  localparam int F_RDAT_LSB  = 16;
  localparam int F_WSTB_BIT  = 24;
  localparam int F_RSTB_BIT  = 25;
  localparam int F_ACK_BIT   = 26;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_BUSY  = 2'd1,
    HS_ACKED = 2'd2
  } hs_state_t;

  typedef struct packed {
    logic            wstb;
    logic            rstb;
    logic [PD_W-1:0] wbyte;
    logic [PA_W-1:0] addr;
  } ctl_fields_t;

  // Delay entries live at 0..8 and 11..13; everything else is a hole.
  function automatic logic phy_addr_mapped(input logic [PA_W-1:0] a);
    return (a <= PA_W'(8)) || ((a >= PA_W'(11)) && (a <= PA_W'(13)));
  endfunction

endpackage

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
  import phyport_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phy_req,
  input  logic            phy_we,
  input  logic [PA_W-1:0] phy_addr,
  input  logic [PD_W-1:0] phy_wdata,
  output logic [PD_W-1:0] phy_rdata,
  output logic            phy_done
);

  localparam int DEPTH = 1 << PA_W;
  localparam int CW    = (LAT < 2) ? 1 : $clog2(LAT);

  logic [PD_W-1:0] mem [DEPTH];
  logic            busy;
  logic [CW-1:0]   cnt;
  logic            fire;
  logic            mapped;

  assign fire   = busy && (cnt == '0);
  assign mapped = phy_addr_mapped(phy_addr);

  always_ff @(posedge clk) begin
    if (fire && phy_we && mapped) begin
      mem[phy_addr] <= phy_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      phy_done  <= 1'b0;
      phy_rdata <= '0;
    end else begin
      phy_done <= 1'b0;
      if (busy) begin
        if (fire) begin
          busy      <= 1'b0;
          phy_done  <= 1'b1;
          phy_rdata <= (mapped && !phy_we) ? mem[phy_addr] : '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (phy_req && !phy_done) begin
        busy <= 1'b1;
        cnt  <= CW'(LAT - 1);
      end
    end
  end

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    phy_done |-> $past(phy_req));

endmodule

// File: rtl/piport_regfile.sv
module piport_regfile
  import phyport_pkg::*;
#(
  parameter int             OFF_W    = 10,
  parameter logic [OFF_W-1:0] WORD_OFF = OFF_W'('h10)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              ack,
  input  logic              cap_en,
  input  logic [PD_W-1:0]   cap_byte,
  output ctl_fields_t       fields
);

  logic              sel;
  logic [PD_W-1:0]   rbyte;
  logic [WORD_W-1:0] image;

  assign sel = (host_off == WORD_OFF);

  always_comb begin
    image = '0;
    image[F_ADDR_LSB +: PA_W] = fields.addr;
    image[F_WDAT_LSB +: PD_W] = fields.wbyte;
    image[F_RDAT_LSB +: PD_W] = rbyte;
    image[F_WSTB_BIT]         = fields.wstb;
    image[F_RSTB_BIT]         = fields.rstb;
    image[F_ACK_BIT]          = ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= '0;
    end else if (host_wr && sel) begin
      fields.addr  <= host_wdata[F_ADDR_LSB +: PA_W];
      fields.wbyte <= host_wdata[F_WDAT_LSB +: PD_W];
      fields.wstb  <= host_wdata[F_WSTB_BIT];
      fields.rstb  <= host_wdata[F_RSTB_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbyte <= '0;
    end else if (cap_en) begin
      rbyte <= cap_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      host_rdata <= sel ? image : '0;
    end
  end

endmodule

// File: rtl/piport_handshake.sv
module piport_handshake
  import phyport_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctl_fields_t     fields,
  input  logic            phy_done,
  input  logic [PD_W-1:0] phy_rdata,
  output logic            phy_req,
  output logic            phy_we,
  output logic [PA_W-1:0] phy_addr,
  output logic [PD_W-1:0] phy_wdata,
  output logic            ack,
  output logic            cap_en,
  output logic [PD_W-1:0] cap_byte
);

  hs_state_t state;
  logic      any_stb;

  assign any_stb  = fields.wstb || fields.rstb;
  assign ack      = (state == HS_ACKED);
  assign cap_en   = (state == HS_BUSY) && phy_done && !phy_we;
  assign cap_byte = phy_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HS_IDLE;
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (any_stb) begin
            state     <= HS_BUSY;
            phy_req   <= 1'b1;
            phy_we    <= fields.wstb;
            phy_addr  <= fields.addr;
            phy_wdata <= fields.wbyte;
          end
        end
        HS_BUSY: begin
          if (phy_done) begin
            state   <= HS_ACKED;
            phy_req <= 1'b0;
          end
        end
        HS_ACKED: begin
          if (!any_stb) begin
            state <= HS_IDLE;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req && !phy_done |=> phy_req);
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req && phy_done |=> !phy_req);
  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req && phy_done |=> ack);
  // R6
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> $past(!fields.wstb && !fields.rstb));
  // R8
  no_req_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !phy_req);
  // R4
  launch_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_req) |-> $past(fields.wstb || fields.rstb));
  // R4
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req && $past(phy_req) |-> $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata));

endmodule

// File: rtl/phy_indirect_port.sv
module phy_indirect_port
  import phyport_pkg::*;
#(
  parameter int               OFF_W    = 10,
  parameter logic [OFF_W-1:0] WORD_OFF = OFF_W'('h10)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [5:0]        phy_addr,
  output logic [7:0]        phy_wdata,
  input  logic [7:0]        phy_rdata,
  input  logic              phy_done
);

  ctl_fields_t     fields;
  logic            ack;
  logic            cap_en;
  logic [PD_W-1:0] cap_byte;

  piport_regfile #(
    .OFF_W    (OFF_W),
    .WORD_OFF (WORD_OFF)
  ) regs_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_off   (host_off),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ack        (ack),
    .cap_en     (cap_en),
    .cap_byte   (cap_byte),
    .fields     (fields)
  );

  piport_handshake hs_i (
    .clk       (clk),
    .rst       (rst),
    .fields    (fields),
    .phy_done  (phy_done),
    .phy_rdata (phy_rdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .ack       (ack),
    .cap_en    (cap_en),
    .cap_byte  (cap_byte)
  );

endmodule

// File: tb/phy_indirect_port_tb_top.sv
module phy_indirect_port_tb_top;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [9:0]  host_off = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we, phy_done;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata, phy_rdata;

  always #2 clk = ~clk;  // 250 MHz

  phy_indirect_port dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_done(phy_done)
  );

  phy_delay_bank #(.LAT(LAT)) bank_i (
    .clk(clk), .rst(rst), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
    .phy_done(phy_done)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  int   nchk = 0;
  int   nfail = 0;
  logic rd_d = 1'b0;
  logic finished = 1'b0;
  logic [7:0] bm [64];
  logic [7:0] cur_rb = 8'h00;

  function automatic logic mapped(input logic [5:0] a);
    return (a <= 6'd8) || (a >= 6'd11 && a <= 6'd13);
  endfunction

  function automatic logic [31:0] img(input logic [5:0] a, input logic [7:0] d,
                                      input logic [7:0] r, input logic ws,
                                      input logic rs, input logic ak);
    return {5'b0, ak, rs, ws, r, d, 2'b0, a};
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] expv, input string tag);
    nchk++;
    if (got !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, expv);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_d <= host_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R3 unexpected read actual=%h expected=none", host_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(host_rdata, e.val, e.tag);
      end
    end
  end

  task automatic hwrite(input logic [9:0] off, input logic [31:0] d);
    host_wr = 1'b1; host_off = off; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [9:0] off, input logic [31:0] expv, input string tag);
    exp_t e;
    e.val = expv; e.tag = tag;
    exp_q.push_back(e);
    host_rd = 1'b1; host_off = off;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!phy_done && n < 100) begin @(negedge clk); n++; end
  endtask

  // launches one access and checks launch, latency and acknowledge rise
  task automatic access(input logic is_rd, input logic both, input logic [5:0] a,
                        input logic [7:0] d);
    int lat;
    logic ws, rs;
    ws = !is_rd || both;
    rs = is_rd || both;
    hwrite(10'h10, img(a, d, 8'h00, 1'b0, 1'b0, 1'b0));
    hwrite(10'h10, img(a, d, 8'h5A, ws, rs, 1'b1));
    chk({31'b0, phy_req}, 32'd0, "R4 req not yet raised");
    @(negedge clk);
    chk({31'b0, phy_req}, 32'd1, "R4 req raised");
    chk({31'b0, phy_we}, {31'b0, ws}, "R4 direction");
    chk({26'b0, phy_addr}, {26'b0, a}, "R4 address");
    chk({24'b0, phy_wdata}, {24'b0, d}, "R4 write byte");
    lat = 1;
    @(negedge clk);
    while (!phy_done && lat < 100) begin
      chk({31'b0, phy_req}, 32'd1, "R5 req held");
      @(negedge clk); lat++;
    end
    chk(lat, LAT + 1, "R9 latency");
    hread(10'h10, img(a, d, cur_rb, ws, rs, 1'b0), "R6 ack not before done");
    chk({31'b0, phy_req}, 32'd0, "R5 req dropped");
    if (ws) begin
      if (mapped(a)) bm[a] = d;
    end else begin
      cur_rb = mapped(a) ? bm[a] : 8'h00;
    end
    hread(10'h10, img(a, d, cur_rb, ws, rs, 1'b1), "R6 R7 ack and read byte");
  endtask

  task automatic release_stb(input logic [5:0] a, input logic [7:0] d);
    hwrite(10'h10, img(a, d, 8'hC3, 1'b0, 1'b0, 1'b1));
    hread(10'h10, img(a, d, cur_rb, 1'b0, 1'b0, 1'b1), "R6 ack lingers one cycle");
    hread(10'h10, img(a, d, cur_rb, 1'b0, 1'b0, 1'b0), "R6 ack fell");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({30'b0, phy_req, phy_we}, 32'd0, "R1 phy side idle");
    hread(10'h10, 32'h0, "R1 word after reset");

    // R2 packing, read-only fields and reserved bits ignored
    hwrite(10'h10, 32'hFCFF_FFFF);
    hread(10'h10, 32'h0000_FF3F, "R2 packing");
    chk({31'b0, phy_req}, 32'd0, "R2 no launch without strobe");

    // R3 offset decoding
    hwrite(10'h14, 32'h0100_1234);
    hread(10'h10, 32'h0000_FF3F, "R3 other offset write ignored");
    hread(10'h14, 32'h0, "R3 other offset reads zero");
    chk({31'b0, phy_req}, 32'd0, "R3 no launch from other offset");

    // write then read back a delay entry
    access(1'b0, 1'b0, 6'h05, 8'hA5);
    release_stb(6'h05, 8'hA5);
    access(1'b1, 1'b0, 6'h05, 8'h00);
    release_stb(6'h05, 8'h00);
    chk({24'b0, cur_rb}, 32'h0000_00A5, "R7 read returned stored byte");

    // R7 read byte retained across a write
    access(1'b0, 1'b0, 6'h0B, 8'h3C);
    release_stb(6'h0B, 8'h3C);

    // R8 strobe set while ack high starts nothing
    access(1'b0, 1'b0, 6'h0C, 8'h11);
    hwrite(10'h10, img(6'h0C, 8'h11, 8'h00, 1'b1, 1'b1, 1'b0));
    for (int i = 0; i < 6; i++) begin
      chk({31'b0, phy_req}, 32'd0, "R8 no request while acked");
      @(negedge clk);
    end
    hread(10'h10, img(6'h0C, 8'h11, cur_rb, 1'b1, 1'b1, 1'b1), "R8 ack still high");
    release_stb(6'h0C, 8'h11);
    for (int i = 0; i < 4; i++) begin
      chk({31'b0, phy_req}, 32'd0, "R8 stale strobe never launched");
      @(negedge clk);
    end

    // R4 both strobes: write wins
    access(1'b0, 1'b1, 6'h0D, 8'h77);
    release_stb(6'h0D, 8'h77);

    // R9 unmapped address: write dropped, read returns zero
    access(1'b0, 1'b0, 6'h09, 8'h55);
    release_stb(6'h09, 8'h55);
    access(1'b1, 1'b0, 6'h09, 8'h00);
    release_stb(6'h09, 8'h00);
    chk({24'b0, cur_rb}, 32'h0, "R9 hole reads zero");
    access(1'b1, 1'b0, 6'h0C, 8'h00);
    release_stb(6'h0C, 8'h00);
    chk({24'b0, cur_rb}, 32'h0000_0011, "R9 mapped entry kept");
    access(1'b1, 1'b0, 6'h0D, 8'h00);
    release_stb(6'h0D, 8'h00);
    chk({24'b0, cur_rb}, 32'h0000_0077, "R4 R9 both-strobe access wrote");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL R3 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule